// File: doc/BRIEF.md
# RAS/CAS DRAM Single-Word Access Sequencer

This block runs one 16-bit access to an asynchronous DRAM with a multiplexed row/column address. It does this each time the host requests one. The host pulses `start` with `wr_sel` and `wdata`. The sequencer then steps through a fixed series of states, and each state sets the DRAM control pins. When the access is over, it pulses `done` for one clock.

A read takes five states. It presents the row half of the address, then the column half. It then strobes RAS and CAS, captures the data bus, and hands the word to `rdata`. A write takes seven states. It first does the same read steps and captures the stored word. It then releases CAS while RAS stays low, drives the host word on both byte lanes, asserts WE, and strobes CAS a second time. Between accesses the sequencer sits idle with every strobe released, which gives the DRAM its precharge time. The address multiplexer itself and the tristate pad are outside the block. The block only drives their select and enable lines.

Top module: `dram_seq`

## Requirements
- R1: In reset and afterwards, until a start is taken, the outputs are idle: `ras_n`, `cas_n` and `we_n` are 1, `addr_oe`, `dq_oe` and `done` are 0, and `rdata` is 0.
- R2: In the first clock after a start is taken, `addr_col_sel` is 0 (row) and `addr_oe` is 1. All three strobes are 1 (inactive).
- R3: In the second clock, `ras_n` is 0, `addr_col_sel` is 1 (column) and `addr_oe` is 1. `cas_n` and `we_n` are 1.
- R4: In the third clock, `ras_n` and `cas_n` are 0, `addr_col_sel` is 1 and `addr_oe` is 1.
- R5: In the fourth clock, `ras_n` and `cas_n` are 0 and `addr_oe` is 0. The value of `dq_in` at the end of this clock is captured into a 16-bit internal word. Reads and writes both do this.
- R6: In a read's fifth clock, all strobes are 1. The captured word appears on `rdata` from the next clock on and stays there until the next read's fifth clock.
- R7: In a write's fifth clock, `ras_n` is 0 and `cas_n` is 1. `dq_oe` is 1 and `dq_out` equals the `wdata` sampled in the clock the start was taken.
- R8: In a write's sixth clock, `ras_n` and `we_n` are 0, `cas_n` is 1, and `dq_oe` is 1.
- R9: In a write's seventh clock, `ras_n`, `we_n` and `cas_n` are all 0, and `dq_oe` is 1 with the same `dq_out`.
- R10: `done` is 1 for exactly one clock, in the first idle clock after the last state of an access. All strobes are 1 in that clock.
- R11: A `start` that arrives while an access is in progress is ignored. `wr_sel` and `wdata` are sampled only when a start is taken.
- R12: A start that is present in the `done` clock is taken. The new access then begins after that one idle clock, so there is at least one clock with every strobe high between two accesses.
- R13: A write does not change `rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Access request, taken only when idle |
| wr_sel | input | 1 | 1 = write, 0 = read; sampled with start |
| wdata | input | 16 | Word to write; sampled with start |
| rdata | output | 16 | Last word read |
| done | output | 1 | One-clock completion pulse |
| addr_col_sel | output | 1 | Address mux select: 0 row, 1 column |
| addr_oe | output | 1 | Address driver enable |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| dq_in | input | 16 | Data bus as seen from the DRAM |
| dq_out | output | 16 | Data to drive onto the bus |
| dq_oe | output | 1 | Data bus drive enable |

## Verification
The assertions assume that `start`, `wr_sel` and `wdata` are synchronous to `clk`. They also assume that reset is held for at least one edge before any check is relied on. No assumption is made about when `start` arrives. The stimulus changes every input one time unit after the rising edge, so there are no races. It drives `dq_in` with a new value every clock, so capture in the wrong state gives a wrong word. It also holds `start` high for long stretches while `wr_sel` and `wdata` change randomly, which exercises starts that arrive while busy and back-to-back accesses.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ROW  = 3'd1,
    ST_RAS  = 3'd2,
    ST_CAS  = 3'd3,
    ST_CAPT = 3'd4,
    ST_FIN  = 3'd5,
    ST_WE   = 3'd6,
    ST_WCAS = 3'd7
  } st_e;

  // Internal control levels, all active high.
  typedef struct packed {
    logic col;
    logic aoe;
    logic ras;
    logic cas;
    logic we;
    logic doe;
  } ctl_t;

  function automatic ctl_t ctl_of(st_e s, logic wr);
    ctl_t c;
    c = '0;
    unique case (s)
      ST_ROW:  c.aoe = 1'b1;
      ST_RAS:  begin c.ras = 1'b1; c.col = 1'b1; c.aoe = 1'b1; end
      ST_CAS:  begin c.ras = 1'b1; c.cas = 1'b1; c.col = 1'b1; c.aoe = 1'b1; end
      ST_CAPT: begin c.ras = 1'b1; c.cas = 1'b1; end
      ST_FIN:  begin c.ras = wr; c.doe = wr; end
      ST_WE:   begin c.ras = 1'b1; c.we = 1'b1; c.doe = 1'b1; end
      ST_WCAS: begin c.ras = 1'b1; c.we = 1'b1; c.cas = 1'b1; c.doe = 1'b1; end
      default: c = '0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/dram_seq_fsm.sv
module dram_seq_fsm
  import dram_seq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic wr_sel,
  output st_e  state_q,
  output st_e  state_d,
  output logic wr_q,
  output logic wr_d,
  output logic accept,
  output logic done_q
);

  logic last;

  always_comb begin
    state_d = state_q;
    accept  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start) begin accept = 1'b1; state_d = ST_ROW; end
      ST_ROW:  state_d = ST_RAS;
      ST_RAS:  state_d = ST_CAS;
      ST_CAS:  state_d = ST_CAPT;
      ST_CAPT: state_d = ST_FIN;
      ST_FIN:  state_d = wr_q ? ST_WE : ST_IDLE;
      ST_WE:   state_d = ST_WCAS;
      ST_WCAS: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign last = ((state_q == ST_FIN) && !wr_q) || (state_q == ST_WCAS);
  assign wr_d = accept ? wr_sel : wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      wr_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      wr_q    <= wr_d;
      done_q  <= last;
    end
  end

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  // R11
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_IDLE && start) |=> $stable(wr_q));

endmodule

// File: rtl/dram_seq_ctl.sv
module dram_seq_ctl
  import dram_seq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  st_e  state_d,
  input  logic wr_d,
  output logic addr_col_sel,
  output logic addr_oe,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic dq_oe
);

  ctl_t ctl_q;

  always_ff @(posedge clk) begin
    if (rst) ctl_q <= '0;
    else     ctl_q <= ctl_of(state_d, wr_d);
  end

  assign addr_col_sel = ctl_q.col;
  assign addr_oe      = ctl_q.aoe;
  assign ras_n        = ~ctl_q.ras;
  assign cas_n        = ~ctl_q.cas;
  assign we_n         = ~ctl_q.we;
  assign dq_oe        = ctl_q.doe;

  // R2
  row_before_ras_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) |-> ($past(addr_oe) && !$past(addr_col_sel) && $past(cas_n)));

  // R4
  cas_inside_ras_chk: assert property (@(posedge clk) disable iff (rst)
    !cas_n |-> !ras_n);

  // R8
  we_needs_drive_chk: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> (!ras_n && dq_oe));

endmodule

// File: rtl/dram_seq_data.sv
module dram_seq_data
  import dram_seq_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  logic [DW-1:0] wdata,
  input  st_e           state_q,
  input  st_e           state_d,
  input  logic          wr_q,
  input  logic [DW-1:0] dq_in,
  output logic [DW-1:0] dq_out,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] wbuf_q;
  logic [DW-1:0] cap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wbuf_q <= '0;
      cap_q  <= '0;
      rdata  <= '0;
      dq_out <= '0;
    end else begin
      if (accept)                          wbuf_q <= wdata;
      if (state_q == ST_CAPT)              cap_q  <= dq_in;
      if (state_q == ST_FIN && !wr_q)      rdata  <= cap_q;
      if (state_d == ST_FIN && wr_q)       dq_out <= wbuf_q;
    end
  end

  // R13
  write_keeps_rdata_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_q && state_q != ST_IDLE) |=> $stable(rdata));

endmodule

// File: rtl/dram_seq.sv
module dram_seq
  import dram_seq_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          wr_sel,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          done,
  output logic          addr_col_sel,
  output logic          addr_oe,
  output logic          ras_n,
  output logic          cas_n,
  output logic          we_n,
  input  logic [DW-1:0] dq_in,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe
);

  st_e  state_q, state_d;
  logic wr_q, wr_d, accept;

  dram_seq_fsm u_fsm (
    .clk(clk), .rst(rst), .start(start), .wr_sel(wr_sel),
    .state_q(state_q), .state_d(state_d), .wr_q(wr_q), .wr_d(wr_d),
    .accept(accept), .done_q(done)
  );

  dram_seq_ctl u_ctl (
    .clk(clk), .rst(rst), .state_d(state_d), .wr_d(wr_d),
    .addr_col_sel(addr_col_sel), .addr_oe(addr_oe),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .dq_oe(dq_oe)
  );

  dram_seq_data #(.DW(DW)) u_data (
    .clk(clk), .rst(rst), .accept(accept), .wdata(wdata),
    .state_q(state_q), .state_d(state_d), .wr_q(wr_q),
    .dq_in(dq_in), .dq_out(dq_out), .rdata(rdata)
  );

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (ras_n && cas_n && we_n && !dq_oe));

endmodule

// File: tb/dram_seq_bench.sv
module dram_seq_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        wr_sel = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] dq_in = '0;
  logic [15:0] rdata, dq_out;
  logic        done, addr_col_sel, addr_oe, ras_n, cas_n, we_n, dq_oe;

  always #5 clk = ~clk;

  dram_seq u_dram_seq (
    .clk(clk), .rst(rst), .start(start), .wr_sel(wr_sel), .wdata(wdata),
    .rdata(rdata), .done(done), .addr_col_sel(addr_col_sel), .addr_oe(addr_oe),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  // Reference model state
  int          m_ph = 0;
  bit          m_wr = 0;
  bit          m_done = 0;
  logic [15:0] m_wbuf = '0, m_cap = '0, m_rd = '0, m_dqo = '0;

  // {col, aoe, ras, cas, we, doe}, active high
  function automatic logic [5:0] exp_ctl(int ph, bit wr);
    case (ph)
      1: return 6'b010000;
      2: return 6'b111000;
      3: return 6'b111100;
      4: return 6'b001100;
      5: return wr ? 6'b001001 : 6'b000000;
      6: return 6'b001011;
      7: return 6'b001111;
      default: return 6'b000000;
    endcase
  endfunction

  function automatic string tag_of(int ph, bit wr);
    case (ph)
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      5: return wr ? "R7" : "R6";
      6: return "R8";
      7: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(bit ok, string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s cycle=%0d actual=%h expected=%h", req, cyc, got, exp);
    end
  endtask

  // Behavioural reference, advanced on each rising edge
  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_ph = 0; m_wr = 0; m_done = 0;
      m_wbuf = '0; m_cap = '0; m_rd = '0; m_dqo = '0;
    end else begin
      m_done = (m_ph == 5 && !m_wr) || m_ph == 7;
      if (m_ph == 5 && !m_wr) m_rd = m_cap;
      if (m_ph == 4) m_cap = dq_in;
      if (m_ph == 0) begin
        if (start) begin m_ph = 1; m_wr = wr_sel; m_wbuf = wdata; end
      end else if ((m_ph == 5 && !m_wr) || m_ph == 7) begin
        m_ph = 0;
      end else begin
        m_ph = m_ph + 1;
      end
      if (m_ph == 5 && m_wr) m_dqo = m_wbuf;
    end
  end

  // Fresh bus value each clock so the capture point is observable (R5)
  always @(posedge clk) begin
    #1 dq_in <= 16'(cyc * 937) ^ 16'h5c21;
  end

  // Compare on every falling edge
  always @(negedge clk) begin
    if (!rst) begin
      logic [5:0] got;
      got = {addr_col_sel, addr_oe, ~ras_n, ~cas_n, ~we_n, dq_oe};
      check(got == exp_ctl(m_ph, m_wr), tag_of(m_ph, m_wr), 32'(got), 32'(exp_ctl(m_ph, m_wr)));
      check(done == m_done, "R10", 32'(done), 32'(m_done));
      check(rdata == m_rd, m_wr ? "R13" : "R6", 32'(rdata), 32'(m_rd));
      if (exp_ctl(m_ph, m_wr)[0])
        check(dq_out == m_dqo, "R7", 32'(dq_out), 32'(m_dqo));
    end
  end

  task automatic req(bit wr, logic [15:0] d);
    @(posedge clk); #1;
    start = 1'b1; wr_sel = wr; wdata = d;
    @(posedge clk); #1;
    start = 1'b0; wr_sel = 1'($random); wdata = 16'($random);
    repeat (9) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1: idle levels after reset
    check(ras_n && cas_n && we_n && !addr_oe && !dq_oe && !done && rdata == 16'h0,
          "R1", {26'h0, ras_n, cas_n, we_n, addr_oe, dq_oe, done}, 32'h38);
    req(1'b0, 16'h0000);
    req(1'b1, 16'hA5C3);
    req(1'b0, 16'h0000);
    req(1'b1, 16'hFFFF);
    req(1'b1, 16'h0001);
    // R11 and R12: start held high, inputs change while busy
    @(posedge clk); #1 start = 1'b1;
    for (int i = 0; i < 60; i++) begin
      wr_sel = 1'($random); wdata = 16'($random);
      @(posedge clk); #1;
    end
    start = 1'b0;
    for (int k = 0; k < 12; k++) req(1'($random), 16'($random));
    repeat (10) @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule